// File: doc/BRIEF.md
# Standby Clock Sequencer

This block decides which clock domains keep running while the processor waits for an interrupt. A one-cycle `idleReq` strobe marks the moment software asks to stop. On that cycle the block samples three halt bits from a configuration register. These bits select one of four standby levels. Each level switches off more of the clock tree than the one before it: plain idle, core halt, core-plus-peripheral halt and full halt. The gating cells, the PLL and the instruction pipeline are outside the block. It drives only their enable and flag outputs.

The block runs from a clock that is never gated, so an interrupt can wake it from any level. When `irqPending` is seen, every clock enable goes back on at once. Instruction issue stays held for a fixed wake latency of two cycles by default. After that a one-cycle resume strobe marks restart at the instruction after the idle. When the chosen level dropped the pipeline contents, a flush indication pulses together with the resume strobe.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: During and immediately after reset the block is in the running state: `coreClkEn`, `periphClkEn`, `pllEn`, `pipeRetain` and `issueEn` are 1, and `resumeStrobe` and `pipeFlush` are 0.
- R2: The level is decoded from the halt bits sampled on the edge where `idleReq` is seen, with this priority. `cfgHaltAll`=1 selects full halt. Otherwise `cfgHaltPeriph`=1 selects core-plus-peripheral halt. Otherwise `cfgHaltCore`=1 selects core halt. With no bit set, the level is plain idle.
- R3: In plain idle `issueEn` is 0 while the core clock, peripheral clock and PLL enables all stay 1 and `pipeRetain` stays 1.
- R4: In core halt `coreClkEn` is 0, `periphClkEn` and `pllEn` stay 1, and `pipeRetain` is 1.
- R5: In core-plus-peripheral halt `coreClkEn` and `periphClkEn` are 0, `pllEn` stays 1, and `pipeRetain` is 0.
- R6: In full halt `coreClkEn`, `periphClkEn` and `pllEn` are all 0, and `pipeRetain` is 0.
- R7: Once a level is entered, the halt bits are ignored. So is `idleReq` in every state but running. Outputs in standby and during the wake latency do not change because of them.
- R8: `irqPending` is sampled on every edge, including while the core clock is gated. On the first edge where it is seen in standby, all three clock enables return to 1 while `issueEn` stays 0. Exactly 2 cycles later (`WAKE_LAT`) `issueEn` returns to 1 and `resumeStrobe` is 1 for exactly one cycle.
- R9: `pipeFlush` is 1 in the cycle of `resumeStrobe` exactly when the level left was core-plus-peripheral halt or full halt. Otherwise it is 0. `pipeRetain` is 1 again from that cycle on.
- R10: While running, `irqPending` has no effect: `resumeStrobe` and `pipeFlush` stay 0 and all enables stay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, never gated |
| rstN | input | 1 | Active-low asynchronous reset |
| idleReq | input | 1 | One-cycle request to enter standby |
| cfgHaltCore | input | 1 | Halt bit: stop the core clock |
| cfgHaltPeriph | input | 1 | Halt bit: stop core and peripheral clocks |
| cfgHaltAll | input | 1 | Halt bit: stop all clocks and the PLL |
| irqPending | input | 1 | Interrupt pending, wake source |
| coreClkEn | output | 1 | Enable for the core clock gate |
| periphClkEn | output | 1 | Enable for the peripheral clock gate |
| pllEn | output | 1 | PLL enable |
| pipeRetain | output | 1 | Pipeline contents are being kept |
| issueEn | output | 1 | Core may issue instructions |
| resumeStrobe | output | 1 | One-cycle pulse when execution restarts |
| pipeFlush | output | 1 | Pipeline must be refilled; pulses with resume |

## Verification
The bench sweeps all eight halt-bit patterns, each with the interrupt idle and with it already pending at entry. This covers the priority overlaps: a design that checked `cfgHaltCore` first would hold the PLL in a full-halt request. An interrupt pending at entry must still pass through one standby cycle. A design that skipped it, or that waited for the core clock to wake, would either never leave or resume a cycle early. Toggling the halt bits and strobing `idleReq` during standby and during the wake latency catches a design that re-samples the configuration or restarts entry. Counting the wake cycles and checking `pipeFlush` per level exposes an off-by-one latency and a flush raised after a retained-pipeline halt.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    LVL_IDLE       = 2'd0,
    LVL_HALT_CORE  = 2'd1,
    LVL_HALT_CP    = 2'd2,
    LVL_HALT_ALL   = 2'd3
  } lpmLevel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic enterSleep;
    logic beginWake;
    logic finishWake;
  } lpmStrobe_t;

  typedef struct packed {
    logic coreEn;
    logic periphEn;
    logic pllEn;
    logic retain;
  } gateSet_t;

  function automatic lpmLevel_t decodeLevel(input logic haltAll,
                                            input logic haltPeriph,
                                            input logic haltCore);
    if (haltAll)         return LVL_HALT_ALL;
    else if (haltPeriph) return LVL_HALT_CP;
    else if (haltCore)   return LVL_HALT_CORE;
    else                 return LVL_IDLE;
  endfunction

  function automatic gateSet_t gatesFor(input lpmLevel_t lvl);
    gateSet_t g;
    g.coreEn   = (lvl == LVL_IDLE);
    g.periphEn = (lvl == LVL_IDLE) || (lvl == LVL_HALT_CORE);
    g.pllEn    = (lvl != LVL_HALT_ALL);
    g.retain   = (lvl == LVL_IDLE) || (lvl == LVL_HALT_CORE);
    return g;
  endfunction

endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int WAKE_LAT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       idleReq,
  input  logic       irqPending,
  output lpmStrobe_t strb
);

  localparam int CW = (WAKE_LAT < 2) ? 1 : $clog2(WAKE_LAT);
  localparam logic [CW-1:0] LAST = CW'(WAKE_LAT - 1);

  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_WAKE} ctlState_t;

  ctlState_t state, stateNext;
  logic [CW-1:0] wakeCnt;

  always_comb begin
    strb.enterSleep = (state == ST_RUN)   && idleReq;
    strb.beginWake  = (state == ST_SLEEP) && irqPending;
    strb.finishWake = (state == ST_WAKE)  && (wakeCnt == LAST);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN:   if (strb.enterSleep) stateNext = ST_SLEEP;
      ST_SLEEP: if (strb.beginWake)  stateNext = ST_WAKE;
      ST_WAKE:  if (strb.finishWake) stateNext = ST_RUN;
      default:  stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      wakeCnt <= '0;
    end else begin
      state <= stateNext;
      if (strb.beginWake || strb.finishWake) wakeCnt <= '0;
      else if (state == ST_WAKE)             wakeCnt <= wakeCnt + 1'b1;
    end
  end

endmodule

// File: rtl/lpm_gate_dp.sv
module lpm_gate_dp
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  lpmStrobe_t strb,
  input  logic       cfgHaltCore,
  input  logic       cfgHaltPeriph,
  input  logic       cfgHaltAll,
  output logic       coreClkEn,
  output logic       periphClkEn,
  output logic       pllEn,
  output logic       pipeRetain,
  output logic       issueEn,
  output logic       resumeStrobe,
  output logic       pipeFlush
);

  lpmLevel_t levelNow;
  gateSet_t  gateNow;

  always_comb begin
    levelNow = decodeLevel(cfgHaltAll, cfgHaltPeriph, cfgHaltCore);
    gateNow  = gatesFor(levelNow);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreClkEn    <= 1'b1;
      periphClkEn  <= 1'b1;
      pllEn        <= 1'b1;
      pipeRetain   <= 1'b1;
      issueEn      <= 1'b1;
      resumeStrobe <= 1'b0;
      pipeFlush    <= 1'b0;
    end else begin
      resumeStrobe <= 1'b0;
      pipeFlush    <= 1'b0;
      if (strb.enterSleep) begin
        coreClkEn   <= gateNow.coreEn;
        periphClkEn <= gateNow.periphEn;
        pllEn       <= gateNow.pllEn;
        pipeRetain  <= gateNow.retain;
        issueEn     <= 1'b0;
      end
      if (strb.beginWake) begin
        coreClkEn   <= 1'b1;
        periphClkEn <= 1'b1;
        pllEn       <= 1'b1;
      end
      if (strb.finishWake) begin
        issueEn      <= 1'b1;
        resumeStrobe <= 1'b1;
        pipeFlush    <= !pipeRetain;
        pipeRetain   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int WAKE_LAT = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic idleReq,
  input  logic cfgHaltCore,
  input  logic cfgHaltPeriph,
  input  logic cfgHaltAll,
  input  logic irqPending,
  output logic coreClkEn,
  output logic periphClkEn,
  output logic pllEn,
  output logic pipeRetain,
  output logic issueEn,
  output logic resumeStrobe,
  output logic pipeFlush
);

  lpmStrobe_t strb;

  lpm_ctrl #(.WAKE_LAT(WAKE_LAT)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .idleReq    (idleReq),
    .irqPending (irqPending),
    .strb       (strb)
  );

  lpm_gate_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .cfgHaltCore  (cfgHaltCore),
    .cfgHaltPeriph(cfgHaltPeriph),
    .cfgHaltAll   (cfgHaltAll),
    .coreClkEn    (coreClkEn),
    .periphClkEn  (periphClkEn),
    .pllEn        (pllEn),
    .pipeRetain   (pipeRetain),
    .issueEn      (issueEn),
    .resumeStrobe (resumeStrobe),
    .pipeFlush    (pipeFlush)
  );

endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic idleReq,
  input logic irqPending,
  input logic coreClkEn,
  input logic periphClkEn,
  input logic pllEn,
  input logic pipeRetain,
  input logic issueEn,
  input logic resumeStrobe,
  input logic pipeFlush
);

  AST_ISSUE_NEEDS_CLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    issueEn |-> (coreClkEn && periphClkEn && pllEn)); // R3

  AST_CORE_OFF_WITH_PERIPH: assert property (@(posedge clk) disable iff (!rstN)
    !periphClkEn |-> !coreClkEn); // R5

  AST_PERIPH_OFF_WITH_PLL: assert property (@(posedge clk) disable iff (!rstN)
    !pllEn |-> (!periphClkEn && !pipeRetain)); // R6

  AST_ENTRY_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(issueEn) |-> $past(idleReq)); // R7

  AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    resumeStrobe |=> !resumeStrobe); // R8

  AST_RESUME_WITH_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(issueEn) |-> resumeStrobe); // R8

  AST_PLL_WAKES_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pllEn) |-> (!issueEn && $past(irqPending))); // R8

  AST_FLUSH_WITH_RESUME: assert property (@(posedge clk) disable iff (!rstN)
    pipeFlush |-> (resumeStrobe && pipeRetain)); // R9

endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .idleReq      (idleReq),
  .irqPending   (irqPending),
  .coreClkEn    (coreClkEn),
  .periphClkEn  (periphClkEn),
  .pllEn        (pllEn),
  .pipeRetain   (pipeRetain),
  .issueEn      (issueEn),
  .resumeStrobe (resumeStrobe),
  .pipeFlush    (pipeFlush)
);

// File: tb/lpm_clk_ctrl_bench.sv
`timescale 1ns/1ps
module lpm_clk_ctrl_bench;

  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic idleReq = 1'b0;
  logic cfgHaltCore = 1'b0, cfgHaltPeriph = 1'b0, cfgHaltAll = 1'b0;
  logic irqPending = 1'b0;
  logic coreClkEn, periphClkEn, pllEn, pipeRetain, issueEn, resumeStrobe, pipeFlush;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lpm_clk_ctrl #(.WAKE_LAT(LAT)) u_lpm_clk_ctrl (
    .clk(clk), .rstN(rstN), .idleReq(idleReq),
    .cfgHaltCore(cfgHaltCore), .cfgHaltPeriph(cfgHaltPeriph), .cfgHaltAll(cfgHaltAll),
    .irqPending(irqPending),
    .coreClkEn(coreClkEn), .periphClkEn(periphClkEn), .pllEn(pllEn),
    .pipeRetain(pipeRetain), .issueEn(issueEn),
    .resumeStrobe(resumeStrobe), .pipeFlush(pipeFlush)
  );

  // order: core, periph, pll, retain, issue, resume, flush
  function automatic logic [6:0] outVec();
    return {coreClkEn, periphClkEn, pllEn, pipeRetain, issueEn, resumeStrobe, pipeFlush};
  endfunction

  task automatic checkOut(input string req, input logic [6:0] exp);
    logic [6:0] act;
    act = outVec();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b (core,periph,pll,retain,issue,resume,flush)",
               req, act, exp);
    end
  endtask

  function automatic string levelReq(input int lvl);
    case (lvl)
      0: return "R2/R3 idle";
      1: return "R2/R4 core halt";
      2: return "R2/R5 core+periph halt";
      default: return "R2/R6 full halt";
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=timeout expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOut("R1 in reset", 7'b1111100);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after reset", 7'b1111100);

    for (int pre = 0; pre < 2; pre++) begin
      for (int cfg = 0; cfg < 8; cfg++) begin
        int lvl;
        logic eCore, ePer, ePll, eRet;
        lvl  = cfg[2] ? 3 : (cfg[1] ? 2 : (cfg[0] ? 1 : 0));
        eCore = (lvl == 0);
        ePer  = (lvl < 2);
        ePll  = (lvl < 3);
        eRet  = (lvl < 2);

        // R10: interrupt while running does nothing
        @(negedge clk);
        irqPending = 1'b1;
        @(negedge clk);
        irqPending = 1'b0;
        checkOut("R10 irq while running", 7'b1111100);

        // enter standby
        cfgHaltCore   = cfg[0];
        cfgHaltPeriph = cfg[1];
        cfgHaltAll    = cfg[2];
        idleReq       = 1'b1;
        irqPending    = (pre == 1);
        @(negedge clk);
        idleReq = 1'b0;
        checkOut(levelReq(lvl), {eCore, ePer, ePll, eRet, 3'b000});

        if (pre == 0) begin
          // R7: halt bits and idle requests ignored in standby
          for (int k = 0; k < 3; k++) begin
            cfgHaltCore   = ~cfgHaltCore;
            cfgHaltPeriph = ~cfgHaltPeriph;
            cfgHaltAll    = ~cfgHaltAll;
            idleReq       = 1'b1;
            @(negedge clk);
            checkOut("R7 standby holds", {eCore, ePer, ePll, eRet, 3'b000});
          end
          idleReq = 1'b0;
        end

        irqPending = 1'b1;
        for (int w = 0; w < LAT; w++) begin
          @(negedge clk);
          irqPending = 1'b0;
          idleReq    = (w == 0);
          checkOut("R8 wake latency", {3'b111, eRet, 3'b000});
        end
        idleReq = 1'b0;
        @(negedge clk);
        checkOut("R8/R9 resume", {4'b1111, 2'b11, !eRet});
        @(negedge clk);
        checkOut("R7/R8 single pulse, no re-entry", 7'b1111100);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule